// File: doc/BRIEF.md
# D-PHY Clock Lane Transmit Sequencer

This block runs the transmit-side control sequence of a D-PHY clock lane in the lane byte-clock domain. When the data-lane side raises its high-speed request, the lane leaves the LP-11 stop level and passes through LP-01 and LP-00. It then drives HS-0 and finally lets the high-speed clock run. When the request drops, the lane keeps the clock toggling for a programmed time, drives HS-0 again, and returns to LP-11. Every phase length is a separate 8-bit count of byte-clock cycles, taken from a register interface that is outside this block.

The sequencer drives the single-ended line levels, a gate that lets the analog serializer toggle the clock, and the two analog enables (high-speed and low-power). Either enable can be taken away from the state machine and driven from a register bit instead. A 4-bit status word reports bias readiness, stop state, an ultra-low-power flag (always clear here) and high-speed activity.

The request side is a level handshake, not a data stream. `hs_req` high asks for the clock. `hs_ready` high means the clock is running and the pre-interval has elapsed. Dropping `hs_req` is acted on only in a cycle where `hs_ready` is high. Before that, a low `hs_req` is held off and has no effect, which is the back-pressure rule.

Top module: `clk_lane_seq`

## Requirements
- R1: After reset the lane is in stop: `lp_dp`=1, `lp_dn`=1, `hs_clk_on`=0, `hs_ready`=0, the state-machine enables are lp=1 and hs=0, and `lane_status[2]`=1.
- R2: From stop, a high `hs_req` in a cycle moves the lane to LP-01 (`lp_dp`=0, `lp_dn`=1) from the next cycle. LP-01 lasts the tLPX count `tmg_lpx` in cycles. The lines never show LP-10.
- R3: LP-01 is followed by LP-00 with the low-power enable on, for the prepare count `tmg_main[31:24]`. That is followed by HS-0 (high-speed enable on, clock gated off) for the zero count `tmg_main[23:16]`.
- R4: The clock then runs (`hs_clk_on`=1). `hs_ready` rises once the clock has run for `tmg_pre` cycles. A low `hs_req` has no effect before `hs_ready` is high, and the clock keeps running while `hs_req` stays high.
- R5: A low `hs_req` seen with `hs_ready` high starts the exit. The clock keeps toggling for the post count `tmg_main[15:8]`, then HS-0 lasts the trail count `tmg_main[7:0]`, then the lane returns to LP-11 stop.
- R6: A count of zero is a phase of one cycle. No phase is ever skipped.
- R7: While `pwr_dn`=1, the lane is forced to stop from the next cycle and stays there, whatever `hs_req` does.
- R8: While `lane_srst`=1, the lane is forced to stop from the next cycle, from any phase.
- R9: `tx_hs_en` equals `hs_en_val` when `hs_en_sel`=1, and otherwise follows the state machine. `tx_lp_en` equals `lp_en_val` when `lp_en_sel`=1, and otherwise follows the state machine.
- R10: `lane_status` is {`mbias_ready`, in-stop, 0, high-speed-active}, MSB first. High-speed-active is the state machine's high-speed enable (HS-0, clock running, post and trail).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_srst | input | 1 | Lane soft reset, active high |
| pwr_dn | input | 1 | Clock lane (whole PHY) power-down |
| mbias_ready | input | 1 | Analog bias ready, reported in status |
| hs_req | input | 1 | Level request for the high-speed clock |
| tmg_main | input | 32 | Counts: prepare, zero, post, trail (MSB to LSB bytes) |
| tmg_pre | input | 8 | Clock-pre count |
| tmg_lpx | input | 8 | tLPX count |
| hs_en_sel | input | 1 | 1: high-speed enable from register |
| hs_en_val | input | 1 | Register value for high-speed enable |
| lp_en_sel | input | 1 | 1: low-power enable from register |
| lp_en_val | input | 1 | Register value for low-power enable |
| hs_ready | output | 1 | Clock running and release allowed |
| lp_dp | output | 1 | Low-power level, positive line |
| lp_dn | output | 1 | Low-power level, negative line |
| hs_clk_on | output | 1 | High-speed clock toggling |
| tx_hs_en | output | 1 | Analog high-speed driver enable |
| tx_lp_en | output | 1 | Analog low-power driver enable |
| lane_status | output | 4 | {mbias_ready, stop, ulps(0), hs_active} |

## Verification
The bench aims at the phase boundaries. Zero counts must still give one cycle, or a design that skips them would jump straight from LP-01 into HS-0. A release given before the pre-interval ends is a second target: a design that acted on it early would cut the clock short. Power-down and soft reset are asserted in the middle of a sequence; a lane that finished its sequence instead of dropping to stop would show up in the very next cycle. Random override selects check that neither enable leaks the state machine's value, and the reverse, while a select is set.

// File: rtl/clk_lane_pkg.sv
package clk_lane_pkg;

  typedef enum logic [2:0] {
    PH_STOP  = 3'd0,
    PH_LPRQ  = 3'd1,
    PH_PREP  = 3'd2,
    PH_ZERO  = 3'd3,
    PH_RUN   = 3'd4,
    PH_POST  = 3'd5,
    PH_TRAIL = 3'd6
  } cl_phase_e;

  // Number of phase counts carried in the packed timing word.
  localparam int unsigned MAIN_FIELDS = 4;

endpackage

// File: rtl/cls_phase_timer.sv
module cls_phase_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt;

  // A zero count is clamped to one so every phase lasts at least a cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= ONE;
    end else if (load) begin
      cnt <= (load_val == '0) ? ONE : load_val;
    end else if (cnt != ONE) begin
      cnt <= cnt - ONE;
    end
  end

  assign last = (cnt == ONE);
endmodule

// File: rtl/cls_seq_fsm.sv
module cls_seq_fsm
  import clk_lane_pkg::*;
#(
  parameter int unsigned CW = 8,
  localparam int unsigned TW = MAIN_FIELDS * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          force_stop,
  input  logic          hs_req,
  input  logic [TW-1:0] tmg_main,
  input  logic [CW-1:0] tmg_pre,
  input  logic [CW-1:0] tmg_lpx,
  output cl_phase_e     phase,
  output logic          run_ready
);
  logic [CW-1:0] c_prep, c_zero, c_post, c_trail;
  assign c_prep  = tmg_main[4*CW-1:3*CW];
  assign c_zero  = tmg_main[3*CW-1:2*CW];
  assign c_post  = tmg_main[2*CW-1:CW];
  assign c_trail = tmg_main[CW-1:0];

  cl_phase_e     nxt;
  logic          t_last;
  logic          t_load;
  logic [CW-1:0] t_val;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_STOP:  if (hs_req)            nxt = PH_LPRQ;
      PH_LPRQ:  if (t_last)            nxt = PH_PREP;
      PH_PREP:  if (t_last)            nxt = PH_ZERO;
      PH_ZERO:  if (t_last)            nxt = PH_RUN;
      PH_RUN:   if (t_last && !hs_req) nxt = PH_POST;
      PH_POST:  if (t_last)            nxt = PH_TRAIL;
      PH_TRAIL: if (t_last)            nxt = PH_STOP;
      default:                         nxt = PH_STOP;
    endcase
    if (force_stop) nxt = PH_STOP;
  end

  // Each phase picks its own count at the edge that enters it.
  always_comb begin
    unique case (nxt)
      PH_LPRQ:  t_val = tmg_lpx;
      PH_PREP:  t_val = c_prep;
      PH_ZERO:  t_val = c_zero;
      PH_RUN:   t_val = tmg_pre;
      PH_POST:  t_val = c_post;
      PH_TRAIL: t_val = c_trail;
      default:  t_val = '0;
    endcase
  end

  assign t_load = (nxt != phase) && !force_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_STOP;
    else        phase <= nxt;
  end

  cls_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .last     (t_last)
  );

  assign run_ready = (phase == PH_RUN) && t_last;
endmodule

// File: rtl/cls_line_decode.sv
module cls_line_decode
  import clk_lane_pkg::*;
(
  input  cl_phase_e phase,
  output logic      lp_dp,
  output logic      lp_dn,
  output logic      clk_on,
  output logic      hs_fsm,
  output logic      lp_fsm
);
  always_comb begin
    lp_dp  = 1'b0;
    lp_dn  = 1'b0;
    clk_on = 1'b0;
    hs_fsm = 1'b0;
    lp_fsm = 1'b0;
    unique case (phase)
      PH_STOP:  begin lp_dp = 1'b1; lp_dn = 1'b1; lp_fsm = 1'b1; end
      PH_LPRQ:  begin lp_dn = 1'b1; lp_fsm = 1'b1; end
      PH_PREP:  lp_fsm = 1'b1;
      PH_ZERO:  hs_fsm = 1'b1;
      PH_RUN:   begin hs_fsm = 1'b1; clk_on = 1'b1; end
      PH_POST:  begin hs_fsm = 1'b1; clk_on = 1'b1; end
      PH_TRAIL: hs_fsm = 1'b1;
      default:  begin lp_dp = 1'b1; lp_dn = 1'b1; lp_fsm = 1'b1; end
    endcase
  end
endmodule

// File: rtl/cls_en_mux.sv
module cls_en_mux #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] fsm_en,
  input  logic [N-1:0] sel,
  input  logic [N-1:0] reg_val,
  output logic [N-1:0] en_out
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign en_out[i] = sel[i] ? reg_val[i] : fsm_en[i];
  end
endmodule

// File: rtl/clk_lane_seq.sv
module clk_lane_seq
  import clk_lane_pkg::*;
#(
  parameter int unsigned CW = 8,
  localparam int unsigned TW = MAIN_FIELDS * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lane_srst,
  input  logic          pwr_dn,
  input  logic          mbias_ready,
  input  logic          hs_req,
  input  logic [TW-1:0] tmg_main,
  input  logic [CW-1:0] tmg_pre,
  input  logic [CW-1:0] tmg_lpx,
  input  logic          hs_en_sel,
  input  logic          hs_en_val,
  input  logic          lp_en_sel,
  input  logic          lp_en_val,
  output logic          hs_ready,
  output logic          lp_dp,
  output logic          lp_dn,
  output logic          hs_clk_on,
  output logic          tx_hs_en,
  output logic          tx_lp_en,
  output logic [3:0]    lane_status
);
  cl_phase_e phase;
  logic      hs_fsm, lp_fsm;
  logic [1:0] en_mux;

  cls_seq_fsm #(.CW(CW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_stop (lane_srst | pwr_dn),
    .hs_req     (hs_req),
    .tmg_main   (tmg_main),
    .tmg_pre    (tmg_pre),
    .tmg_lpx    (tmg_lpx),
    .phase      (phase),
    .run_ready  (hs_ready)
  );

  cls_line_decode u_dec (
    .phase  (phase),
    .lp_dp  (lp_dp),
    .lp_dn  (lp_dn),
    .clk_on (hs_clk_on),
    .hs_fsm (hs_fsm),
    .lp_fsm (lp_fsm)
  );

  // Bit 1 carries the high-speed enable, bit 0 the low-power enable.
  cls_en_mux #(.N(2)) u_mux (
    .fsm_en  ({hs_fsm, lp_fsm}),
    .sel     ({hs_en_sel, lp_en_sel}),
    .reg_val ({hs_en_val, lp_en_val}),
    .en_out  (en_mux)
  );

  assign tx_hs_en    = en_mux[1];
  assign tx_lp_en    = en_mux[0];
  assign lane_status = {mbias_ready, (phase == PH_STOP), 1'b0, hs_fsm};
endmodule

// File: rtl/cls_checker.sv
module cls_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       lane_srst,
  input logic       pwr_dn,
  input logic       hs_req,
  input logic       hs_ready,
  input logic       lp_dp,
  input logic       lp_dn,
  input logic       hs_clk_on,
  input logic       tx_hs_en,
  input logic       tx_lp_en,
  input logic       hs_en_sel,
  input logic       hs_en_val,
  input logic       lp_en_sel,
  input logic       lp_en_val,
  input logic [3:0] lane_status
);
  a_r2_no_lp10: assert property (@(posedge clk) disable iff (!rst_n)
    !(lp_dp && !lp_dn));

  a_r2_req_leaves_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_status[2] && hs_req && !pwr_dn && !lane_srst) |=> (!lp_dp && lp_dn));

  a_r4_hold_while_req: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_ready && hs_req && !pwr_dn && !lane_srst) |=> hs_clk_on);

  a_r5_release_to_post: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_ready && !hs_req && !pwr_dn && !lane_srst) |=> (hs_clk_on && !hs_ready));

  a_r7_pwrdn_stop: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (lp_dp && lp_dn && lane_status[2] && !hs_clk_on));

  a_r8_srst_stop: assert property (@(posedge clk) disable iff (!rst_n)
    lane_srst |=> (lane_status[2] && !hs_ready));

  a_r9_hs_override: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en_sel |-> (tx_hs_en == hs_en_val));

  a_r9_lp_override: assert property (@(posedge clk) disable iff (!rst_n)
    lp_en_sel |-> (tx_lp_en == lp_en_val));

  a_r10_clock_implies_active: assert property (@(posedge clk) disable iff (!rst_n)
    hs_clk_on |-> (lane_status[0] && !lane_status[2] && !lane_status[1]));
endmodule

bind clk_lane_seq cls_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lane_srst   (lane_srst),
  .pwr_dn      (pwr_dn),
  .hs_req      (hs_req),
  .hs_ready    (hs_ready),
  .lp_dp       (lp_dp),
  .lp_dn       (lp_dn),
  .hs_clk_on   (hs_clk_on),
  .tx_hs_en    (tx_hs_en),
  .tx_lp_en    (tx_lp_en),
  .hs_en_sel   (hs_en_sel),
  .hs_en_val   (hs_en_val),
  .lp_en_sel   (lp_en_sel),
  .lp_en_val   (lp_en_val),
  .lane_status (lane_status)
);

// File: tb/clk_lane_seq_tb.sv
module clk_lane_seq_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, lane_srst = 1'b0, pwr_dn = 1'b0, mbias_ready = 1'b0;
  logic        hs_req = 1'b0;
  logic [31:0] tmg_main = '0;
  logic [7:0]  tmg_pre = '0, tmg_lpx = '0;
  logic        hs_en_sel = 1'b0, hs_en_val = 1'b0, lp_en_sel = 1'b0, lp_en_val = 1'b0;
  logic        hs_ready, lp_dp, lp_dn, hs_clk_on, tx_hs_en, tx_lp_en;
  logic [3:0]  lane_status;

  clk_lane_seq u_dut (
    .clk(clk), .rst_n(rst_n), .lane_srst(lane_srst), .pwr_dn(pwr_dn),
    .mbias_ready(mbias_ready), .hs_req(hs_req), .tmg_main(tmg_main),
    .tmg_pre(tmg_pre), .tmg_lpx(tmg_lpx), .hs_en_sel(hs_en_sel),
    .hs_en_val(hs_en_val), .lp_en_sel(lp_en_sel), .lp_en_val(lp_en_val),
    .hs_ready(hs_ready), .lp_dp(lp_dp), .lp_dn(lp_dn), .hs_clk_on(hs_clk_on),
    .tx_hs_en(tx_hs_en), .tx_lp_en(tx_lp_en), .lane_status(lane_status)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // Behavioural reference: phase number 0..6 and cycles left in it.
  // 0 stop, 1 LP-01, 2 LP-00, 3 HS-0 zero, 4 clock run, 5 post, 6 trail
  int mph = 0, mrem = 1;

  function automatic int dur(input logic [7:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mph = 0; mrem = 1;
    end else if (lane_srst || pwr_dn) begin
      mph = 0;
    end else begin
      case (mph)
        0: if (hs_req) begin mph = 1; mrem = dur(tmg_lpx); end
        4: if (mrem > 1) mrem--;
           else if (!hs_req) begin mph = 5; mrem = dur(tmg_main[15:8]); end
        default:
          if (mrem > 1) mrem--;
          else begin
            case (mph)
              1: begin mph = 2; mrem = dur(tmg_main[31:24]); end
              2: begin mph = 3; mrem = dur(tmg_main[23:16]); end
              3: begin mph = 4; mrem = dur(tmg_pre); end
              5: begin mph = 6; mrem = dur(tmg_main[7:0]); end
              default: mph = 0;
            endcase
          end
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the reference.
  int c01, c00, cz, ct;
  bit seen_clk;

  task automatic tick();
    logic hs_m, lp_m;
    @(negedge clk);
    hs_m = (mph >= 3);
    lp_m = (mph <= 2);
    chk("R2 lines", {lp_dp, lp_dn}, (mph == 0) ? 3 : (mph == 1) ? 1 : 0);
    chk("R4 R5 clock gate", hs_clk_on, (mph == 4 || mph == 5));
    chk("R4 hs_ready", hs_ready, (mph == 4 && mrem == 1));
    chk("R9 tx_hs_en", tx_hs_en, hs_en_sel ? hs_en_val : hs_m);
    chk("R9 tx_lp_en", tx_lp_en, lp_en_sel ? lp_en_val : lp_m);
    chk("R10 status", lane_status, {mbias_ready, (mph == 0), 1'b0, hs_m});
    if (lp_dp == 0 && lp_dn == 1) c01++;
    if (hs_clk_on) seen_clk = 1;
    if (!lp_dp && !lp_dn && tx_lp_en) c00++;
    if (tx_hs_en && !hs_clk_on && !seen_clk) cz++;
    if (tx_hs_en && !hs_clk_on && seen_clk) ct++;
  endtask

  // One full sequence. hold: cycles of running clock before release request.
  task automatic run_seq(input logic [7:0] lpx, input logic [7:0] prep,
                         input logic [7:0] zero, input logic [7:0] pre,
                         input logic [7:0] post, input logic [7:0] trail,
                         input int hold, input bit ovr);
    int guard;
    tmg_lpx = lpx; tmg_pre = pre; tmg_main = {prep, zero, post, trail};
    c01 = 0; c00 = 0; cz = 0; ct = 0; seen_clk = 0;
    hs_req = 1'b1;
    guard = 0;
    while (!hs_clk_on && guard < 2000) begin
      if (ovr) begin
        hs_en_sel = 1'($urandom); hs_en_val = 1'($urandom);
        lp_en_sel = 1'($urandom); lp_en_val = 1'($urandom);
      end
      tick(); guard++;
    end
    for (int i = 0; i < hold; i++) tick();
    hs_req = 1'b0;   // early release must wait for hs_ready (R4)
    guard = 0;
    while (!lane_status[2] && guard < 2000) begin
      if (ovr) begin
        hs_en_sel = 1'($urandom); hs_en_val = 1'($urandom);
        lp_en_sel = 1'($urandom); lp_en_val = 1'($urandom);
      end
      tick(); guard++;
    end
    hs_en_sel = 0; lp_en_sel = 0;
    if (!ovr) begin
      chk("R2 tLPX length", c01, dur(lpx));
      chk("R3 prepare length", c00, dur(prep));
      chk("R3 zero length", cz, dur(zero));
      chk("R5 trail length", ct, dur(trail));
    end
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R1 reset lines", {lp_dp, lp_dn}, 3);
    chk("R1 reset enables", {tx_hs_en, tx_lp_en, hs_clk_on, hs_ready}, 4'b0100);
    chk("R1 reset status", lane_status, 4'b0100);

    // R2 R3 R5: directed sequence with distinct counts
    run_seq(8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd2, 0, 0);
    // R6: every count zero
    run_seq(8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 0, 0);
    // R4: release held off by long pre, and long hold
    run_seq(8'd1, 8'd1, 8'd1, 8'd40, 8'd1, 8'd1, 0, 0);
    run_seq(8'd2, 8'd2, 8'd2, 8'd2, 8'd3, 8'd3, 30, 0);
    mbias_ready = 1'b1;   // R10 bias bit
    for (int k = 0; k < 40; k++)
      run_seq(8'($urandom_range(0, 20)), 8'($urandom_range(0, 20)),
              8'($urandom_range(0, 20)), 8'($urandom_range(0, 20)),
              8'($urandom_range(0, 20)), 8'($urandom_range(0, 20)),
              $urandom_range(0, 25), 0);
    // R9: random overrides through whole sequences
    for (int k = 0; k < 10; k++)
      run_seq(8'($urandom_range(0, 6)), 8'($urandom_range(0, 6)),
              8'($urandom_range(0, 6)), 8'($urandom_range(0, 6)),
              8'($urandom_range(0, 6)), 8'($urandom_range(0, 6)),
              $urandom_range(0, 5), 1);

    // R7: power-down mid-sequence, then request held while powered down
    tmg_lpx = 5; tmg_pre = 9; tmg_main = 32'h05050505;
    hs_req = 1'b1;
    repeat (14) tick();
    pwr_dn = 1'b1;
    tick();
    chk("R7 stop after power-down", {lp_dp, lp_dn, lane_status[2]}, 3'b111);
    repeat (10) tick();
    chk("R7 request ignored", {lp_dp, lp_dn, hs_clk_on}, 3'b110);
    pwr_dn = 1'b0;
    repeat (25) tick();
    chk("R7 resumes after power-up", hs_clk_on, 1);

    // R8: soft reset while the clock is running
    lane_srst = 1'b1;
    tick();
    chk("R8 stop after soft reset", {lane_status[2], hs_clk_on}, 2'b10);
    hs_req = 1'b0;
    repeat (3) tick();
    lane_srst = 1'b0;
    repeat (3) tick();
    chk("R8 remains stopped", lane_status[2], 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule